// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block runs once after every reset. It reads an initialization image from an external two-wire serial EEPROM and writes the bytes into the chip's configuration registers. It contains a small two-wire master and a sequencer. The master generates START, STOP and nine-bit byte frames from a divided system clock. The sequencer performs one sequential read from word 00h. It validates the two header bytes, passes every payload byte through a word-to-register table, and checks the closing marker byte.

Each mapped payload byte leaves the block through a plain register-write port (address, data, one-cycle strobe). Three reserved slots in the image are read but produce no write. An 8-bit status output carries a busy bit and an error bit. Other logic waits for busy to fall and then reads the error bit to learn whether the image was accepted.

Top module: `cfg_rom_loader`

## Requirements
- R1: The master sends START, then the byte A0h (device address 1010000b with the write bit 0), then word address 00h. It then sends a repeated START and the byte A1h (read bit 1), and reads bytes sequentially from word 00h onward.
- R2: The byte at word 00h must be 00h. Any other value ends the read with a NACK on that byte and a STOP. The error bit (bit 0) is set and no register write is made.
- R3: The byte at word 01h must be 25h. Any other value ends the read with a NACK on that byte and a STOP. The error bit is set and no register write is made.
- R4: Words 02h–26h are written in word order. Words 02h–05h go to 44h–47h, 06h–0Bh go to D4h–D9h, 0Dh–0Eh go to DCh–DDh, 0Fh–1Ah go to C0h–CBh, 1Dh goes to E0h, 1Eh–1Fh go to E2h–E3h, 20h–22h go to E8h–EAh, and 23h–26h go to ECh–EFh. Each write carries the byte read from that word as its data.
- R5: Words 0Ch, 1Bh and 1Ch are read but produce no write. A full image therefore yields exactly 34 writes.
- R6: The byte at word 27h is the last byte read and is answered with a NACK. If it is not 80h, the error bit is set. Writes already made for words 02h–26h remain.
- R7: If the EEPROM does not acknowledge the device address or the word address, the master sends STOP, sets the error bit and clears busy. No register write is made.
- R8: Status bit 4 (busy) is 1 from reset until the closing STOP has finished, then 0. Bit 0 is the error bit. All other status bits are 0. After busy clears, the status holds until the next reset.
- R9: One SCL period is 4×QDIV system clocks. SDA changes while SCL is high only for START (falling) and STOP (rising). When busy falls, SCL is high and SDA is released.
- R10: The write strobe is high for exactly one clock per mapped byte. Address and data are valid in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; the load starts when it is released |
| scl_o | output | 1 | Two-wire clock (1 = released/high) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_i | input | 1 | Sampled level of the data line |
| reg_addr | output | 8 | Configuration register byte address |
| reg_data | output | 8 | Configuration register byte data |
| reg_we | output | 1 | Single-cycle write strobe |
| stat | output | 8 | Status: bit 4 busy, bit 0 error, others 0 |

## Verification
A byte's register write is due one clock after the master completes the eighth SCL quarter-sequence of that byte. The bench records the strobe, address and data at every falling clock edge, so each pulse is caught in its own cycle and a pulse wider than one clock shows up as a run. Busy falls one clock after the last quarter of STOP. The bench polls status at falling edges and evaluates the final status, the bus levels and the write list only after that point. The bus-level results (device bytes, word address, START/STOP counts, the word that received NACK) come from an EEPROM model that follows SCL and SDA edges. These results are therefore compared once the transfer they belong to is complete.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_START = 2'd1,
        OP_STOP  = 2'd2,
        OP_XFER  = 2'd3
    } tw_op_e;

    typedef enum logic [3:0] {
        S_START1 = 4'd0,
        S_DEVW   = 4'd1,
        S_WADDR  = 4'd2,
        S_START2 = 4'd3,
        S_DEVR   = 4'd4,
        S_RDBYTE = 4'd5,
        S_ACK    = 4'd6,
        S_STOP   = 4'd7,
        S_DONE   = 4'd8
    } seq_st_e;

    localparam logic [6:0] DEV_ADDR   = 7'b1010000;
    localparam int         WORD_W     = 6;
    localparam logic [5:0] WORD_FUNC  = 6'h00;
    localparam logic [5:0] WORD_COUNT = 6'h01;
    localparam logic [5:0] WORD_END   = 6'h27;
    localparam logic [7:0] FUNC_VAL   = 8'h00;
    localparam logic [7:0] COUNT_VAL  = 8'h25;
    localparam logic [7:0] END_MARK   = 8'h80;

endpackage

// File: rtl/cfl_word_map.sv
module cfl_word_map
    import cfl_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [7:0]        addr_o,
    output logic              skip_o
);
    logic [7:0] w;
    assign w = {{(8-WORD_W){1'b0}}, word_i};

    always_comb begin
        skip_o = 1'b0;
        addr_o = 8'h00;
        if (w >= 8'h02 && w <= 8'h05)      addr_o = w + 8'h42;
        else if (w >= 8'h06 && w <= 8'h0B) addr_o = w + 8'hCE;
        else if (w >= 8'h0D && w <= 8'h0E) addr_o = w + 8'hCF;
        else if (w >= 8'h0F && w <= 8'h1A) addr_o = w + 8'hB1;
        else if (w == 8'h1D)               addr_o = w + 8'hC3;
        else if (w >= 8'h1E && w <= 8'h1F) addr_o = w + 8'hC4;
        else if (w >= 8'h20 && w <= 8'h22) addr_o = w + 8'hC8;
        else if (w >= 8'h23 && w <= 8'h26) addr_o = w + 8'hC9;
        else                               skip_o = 1'b1;
    end
endmodule

// File: rtl/cfl_tw_engine.sv
module cfl_tw_engine
    import cfl_pkg::*;
#(
    parameter int QDIV = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  tw_op_e     op_i,
    input  logic [8:0] tx_i,
    input  logic [3:0] len_i,
    input  logic       sda_i,
    output logic       done_o,
    output logic [7:0] rx_o,
    output logic       scl_o,
    output logic       sda_oe
);
    localparam int          CW       = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(QDIV - 1);

    typedef struct packed {
        tw_op_e      op;
        logic [1:0]  ph;
        logic [CW-1:0] cnt;
        logic [3:0]  left;
        logic [8:0]  tx;
        logic [7:0]  rx;
        logic        scl;
        logic        sda;
        logic        done;
    } eng_s;

    eng_s e_d, e_q;

    // returns {scl, sda} for a quarter of an operation
    function automatic logic [1:0] drive_lines(tw_op_e op, logic [1:0] ph, logic b);
        logic [1:0] r;
        r = 2'b11;
        case (op)
            OP_START: case (ph)
                2'd0:    r = 2'b01;
                2'd1:    r = 2'b11;
                2'd2:    r = 2'b10;
                default: r = 2'b00;
            endcase
            OP_STOP: case (ph)
                2'd0:    r = 2'b00;
                2'd1:    r = 2'b10;
                default: r = 2'b11;
            endcase
            OP_XFER: r = (ph == 2'd1 || ph == 2'd2) ? {1'b1, b} : {1'b0, b};
            default: r = 2'b11;
        endcase
        return r;
    endfunction

    always_comb begin
        e_d      = e_q;
        e_d.done = 1'b0;
        if (e_q.op == OP_IDLE) begin
            if (go_i && op_i != OP_IDLE) begin
                e_d.op   = op_i;
                e_d.ph   = 2'd0;
                e_d.cnt  = '0;
                e_d.tx   = tx_i;
                e_d.left = len_i;
                {e_d.scl, e_d.sda} = drive_lines(op_i, 2'd0, tx_i[8]);
            end
        end else if (e_q.cnt != CNT_LAST) begin
            e_d.cnt = e_q.cnt + 1'b1;
        end else begin
            e_d.cnt = '0;
            if (e_q.op == OP_XFER && e_q.ph == 2'd2)
                e_d.rx = {e_q.rx[6:0], sda_i};
            if (e_q.ph == 2'd3) begin
                if (e_q.op == OP_XFER && e_q.left > 4'd1) begin
                    e_d.left = e_q.left - 4'd1;
                    e_d.tx   = {e_q.tx[7:0], 1'b1};
                    e_d.ph   = 2'd0;
                end else begin
                    e_d.op   = OP_IDLE;
                    e_d.done = 1'b1;
                end
            end else begin
                e_d.ph = e_q.ph + 2'd1;
            end
            if (e_d.op != OP_IDLE)
                {e_d.scl, e_d.sda} = drive_lines(e_d.op, e_d.ph, e_d.tx[8]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q      <= '0;
            e_q.op   <= OP_IDLE;
            e_q.scl  <= 1'b1;
            e_q.sda  <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign done_o = e_q.done;
    assign rx_o   = e_q.rx;
    assign scl_o  = e_q.scl;
    assign sda_oe = ~e_q.sda;
endmodule

// File: rtl/cfg_rom_loader.sv
module cfg_rom_loader
    import cfl_pkg::*;
#(
    parameter int QDIV = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       scl_o,
    output logic       sda_oe,
    input  logic       sda_i,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_data,
    output logic       reg_we,
    output logic [7:0] stat
);
    typedef struct packed {
        seq_st_e           st;
        logic              wait_e;
        logic [WORD_W-1:0] word;
        logic              nak;
        logic              err;
        logic              busy;
        logic              we;
        logic [7:0]        addr;
        logic [7:0]        data;
    } seq_s;

    seq_s s_d, s_q;

    logic       e_go, e_done;
    tw_op_e     e_op;
    logic [8:0] e_tx;
    logic [3:0] e_len;
    logic [7:0] e_rx;
    logic [7:0] map_addr;
    logic       map_skip;
    logic       hdr_bad, at_end;

    cfl_tw_engine #(.QDIV(QDIV)) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (e_go),
        .op_i  (e_op),
        .tx_i  (e_tx),
        .len_i (e_len),
        .sda_i (sda_i),
        .done_o(e_done),
        .rx_o  (e_rx),
        .scl_o (scl_o),
        .sda_oe(sda_oe)
    );

    cfl_word_map u_map (
        .word_i(s_q.word),
        .addr_o(map_addr),
        .skip_o(map_skip)
    );

    assign hdr_bad = (s_q.word == WORD_FUNC  && e_rx != FUNC_VAL) ||
                     (s_q.word == WORD_COUNT && e_rx != COUNT_VAL);
    assign at_end  = (s_q.word == WORD_END);

    always_comb begin
        s_d    = s_q;
        s_d.we = 1'b0;
        e_op   = OP_IDLE;
        e_tx   = 9'h1FF;
        e_len  = 4'd0;
        case (s_q.st)
            S_START1, S_START2: e_op = OP_START;
            S_DEVW:   begin e_op = OP_XFER; e_tx = {DEV_ADDR, 1'b0, 1'b1}; e_len = 4'd9; end
            S_WADDR:  begin e_op = OP_XFER; e_tx = {8'h00, 1'b1};          e_len = 4'd9; end
            S_DEVR:   begin e_op = OP_XFER; e_tx = {DEV_ADDR, 1'b1, 1'b1}; e_len = 4'd9; end
            S_RDBYTE: begin e_op = OP_XFER; e_tx = 9'h1FF;                 e_len = 4'd8; end
            S_ACK:    begin e_op = OP_XFER; e_tx = {s_q.nak, 8'hFF};       e_len = 4'd1; end
            S_STOP:   e_op = OP_STOP;
            default:  e_op = OP_IDLE;
        endcase
        e_go = (s_q.st != S_DONE) && !s_q.wait_e;
        if (e_go) s_d.wait_e = 1'b1;

        if (e_done) begin
            s_d.wait_e = 1'b0;
            case (s_q.st)
                S_START1: s_d.st = S_DEVW;
                S_DEVW:   if (e_rx[0]) begin s_d.err = 1'b1; s_d.st = S_STOP; end
                          else s_d.st = S_WADDR;
                S_WADDR:  if (e_rx[0]) begin s_d.err = 1'b1; s_d.st = S_STOP; end
                          else s_d.st = S_START2;
                S_START2: s_d.st = S_DEVR;
                S_DEVR:   if (e_rx[0]) begin s_d.err = 1'b1; s_d.st = S_STOP; end
                          else begin s_d.word = WORD_FUNC; s_d.st = S_RDBYTE; end
                S_RDBYTE: begin
                    if (hdr_bad || (at_end && e_rx != END_MARK)) s_d.err = 1'b1;
                    s_d.nak = hdr_bad || at_end;
                    if (!map_skip) begin
                        s_d.we   = 1'b1;
                        s_d.addr = map_addr;
                        s_d.data = e_rx;
                    end
                    s_d.st = S_ACK;
                end
                S_ACK:    if (s_q.nak) s_d.st = S_STOP;
                          else begin s_d.word = s_q.word + 1'b1; s_d.st = S_RDBYTE; end
                S_STOP:   begin s_d.busy = 1'b0; s_d.st = S_DONE; end
                default:  s_d.st = S_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= S_START1;
            s_q.busy <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_we   = s_q.we;
    assign reg_addr = s_q.addr;
    assign reg_data = s_q.data;
    assign stat     = {3'b000, s_q.busy, 3'b000, s_q.err};
endmodule

// File: rtl/cfg_rom_loader_chk.sv
module cfg_rom_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_o,
    input logic       sda_oe,
    input logic       reg_we,
    input logic [7:0] reg_addr,
    input logic [7:0] stat
);
    // R10: strobe never lasts two clocks
    assert_we_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R4 / R2: writes target mapped space, only during a load with no error
    assert_we_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_addr >= 8'h44) && stat[4] && !stat[0]);

    // R9: bus released and clock high once busy drops
    assert_bus_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[4]) |-> (scl_o && !sda_oe));

    // R9: data edges under a high clock only happen inside the load
    assert_cond_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && (sda_oe != $past(sda_oe))) |-> stat[4]);

    // R8: status frozen after completion
    assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[4] |=> $stable(stat));

    // R8: unused status bits stay zero
    assert_status_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[7:5] == 3'b000) && (stat[3:1] == 3'b000));
endmodule

bind cfg_rom_loader cfg_rom_loader_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_o   (scl_o),
    .sda_oe  (sda_oe),
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .stat    (stat)
);

// File: tb/cfg_rom_loader_bench.sv
`timescale 1ns/1ps
module cfg_rom_loader_bench;
    localparam int QDIV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       scl, sda_oe, sda_line, reg_we;
    logic [7:0] reg_addr, reg_data, stat;
    logic       slv_low;

    assign sda_line = ~(sda_oe | slv_low);

    cfg_rom_loader #(.QDIV(QDIV)) u_cfg_rom_loader (
        .clk(clk), .rst_n(rst_n), .scl_o(scl), .sda_oe(sda_oe), .sda_i(sda_line),
        .reg_addr(reg_addr), .reg_data(reg_data), .reg_we(reg_we), .stat(stat)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] mem [0:63];
    bit nack_dev = 0;
    bit nack_wa  = 0;

    // ---------------- EEPROM model ----------------
    int         mode, bc, starts, stops, n_addr, nack_ptr;
    logic [7:0] sh;
    logic       rw, ackseen, p_scl, p_oe;
    logic [5:0] ptr;
    logic [7:0] addr_log [0:7];

    always @(scl or sda_oe or rst_n) begin
        if (!rst_n) begin
            mode = 0; bc = 0; starts = 0; stops = 0; n_addr = 0; nack_ptr = -1;
            sh = 0; rw = 0; ackseen = 0; ptr = 0; slv_low = 0; p_scl = 1; p_oe = 0;
        end else begin
            if (scl != p_scl) begin
                if (scl) begin
                    if (mode == 1 || mode == 2) begin
                        if (bc < 8) sh = {sh[6:0], sda_line};
                        bc++;
                    end else if (mode == 3) begin
                        if (bc == 8) ackseen = sda_line;
                        bc++;
                    end
                end else begin
                    if (mode == 1) begin
                        if (bc == 8) begin
                            if (n_addr < 8) addr_log[n_addr] = sh;
                            n_addr++;
                            if (sh[7:1] == 7'h50 && !nack_dev) begin slv_low = 1; rw = sh[0]; end
                            else mode = 4;
                        end else if (bc == 9) begin
                            slv_low = 0; bc = 0;
                            if (rw) begin mode = 3; slv_low = ~mem[ptr][7]; end
                            else mode = 2;
                        end
                    end else if (mode == 2) begin
                        if (bc == 8) begin
                            if (n_addr < 8) addr_log[n_addr] = sh;
                            n_addr++;
                            if (!nack_wa) begin slv_low = 1; ptr = sh[5:0]; end
                            else mode = 4;
                        end else if (bc == 9) begin
                            slv_low = 0; mode = 4;
                        end
                    end else if (mode == 3) begin
                        if (bc < 8) slv_low = ~mem[ptr][7-bc];
                        else if (bc == 8) slv_low = 0;
                        else begin
                            if (!ackseen) begin ptr = ptr + 1; bc = 0; slv_low = ~mem[ptr][7]; end
                            else begin nack_ptr = int'(ptr); mode = 4; slv_low = 0; end
                        end
                    end
                end
            end else if (sda_oe != p_oe && scl) begin
                if (sda_oe) begin mode = 1; bc = 0; slv_low = 0; starts++; end
                else begin mode = 0; stops++; end
            end
            p_scl = scl;
            p_oe  = sda_oe;
        end
    end

    // ---------------- write capture ----------------
    logic [7:0] wa [0:63];
    logic [7:0] wd [0:63];
    int nw, run, maxrun;

    always @(negedge clk) begin
        if (!rst_n) begin
            nw = 0; run = 0; maxrun = 0;
        end else if (reg_we) begin
            if (nw < 64) begin wa[nw] = reg_addr; wd[nw] = reg_data; end
            nw++; run++;
            if (run > maxrun) maxrun = run;
        end else begin
            run = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // register byte for a word, -1 when no write is due (R4, R5)
    function automatic int exp_addr(input int w);
        if (w >= 2  && w <= 5)  return 'h44 + (w - 2);
        if (w >= 6  && w <= 11) return 'hD4 + (w - 6);
        if (w >= 13 && w <= 14) return 'hDC + (w - 13);
        if (w >= 15 && w <= 26) return 'hC0 + (w - 15);
        if (w == 29)            return 'hE0;
        if (w >= 30 && w <= 31) return 'hE2 + (w - 30);
        if (w >= 32 && w <= 34) return 'hE8 + (w - 32);
        if (w >= 35 && w <= 38) return 'hEC + (w - 35);
        return -1;
    endfunction

    task automatic build_image(input int kind);
        for (int i = 0; i < 64; i++) mem[i] = 8'hFF;
        mem[0] = 8'h00;
        mem[1] = 8'h25;
        for (int w = 2; w <= 38; w++) begin
            if (kind == 1)      mem[w] = 8'hFF;
            else if (kind == 2) mem[w] = 8'h00;
            else                mem[w] = 8'($urandom);
        end
        mem[39] = 8'h80;
    endtask

    task automatic run_load();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 20000 && stat[4]; i++) @(negedge clk);
        check(!stat[4], "R8", "busy cleared at end of load", int'(stat[4]), 0);
        repeat (20) @(negedge clk);
    endtask

    task automatic check_bus_end(input string req);
        check(scl && !sda_oe, req, "bus idle after load", {scl, sda_oe}, 2);
        check(stops == 1, req, "STOP count", stops, 1);
    endtask

    task automatic check_full_load(input bit err_exp);
        int k;
        logic [7:0] s0;
        k = 0;
        for (int w = 2; w <= 38; w++) begin
            if (exp_addr(w) >= 0) begin
                check(wa[k] == 8'(exp_addr(w)), "R4", "write address", wa[k], exp_addr(w));
                check(wd[k] == mem[w], "R4", "write data", wd[k], mem[w]);
                k++;
            end
        end
        check(nw == 34, "R5", "number of writes", nw, 34);
        check(stat == {7'd0, err_exp}, "R8", "final status", stat, {7'd0, err_exp});
        check(n_addr == 3 && addr_log[0] == 8'hA0 && addr_log[1] == 8'h00 && addr_log[2] == 8'hA1,
              "R1", "address bytes", {addr_log[0], addr_log[1], addr_log[2]}, 24'hA000A1);
        check(starts == 2, "R9", "START count", starts, 2);
        check_bus_end("R9");
        check(maxrun == 1, "R10", "strobe width", maxrun, 1);
        check(nack_ptr == 39, "R6", "word answered with NACK", nack_ptr, 39);
        s0 = stat;
        repeat (50) @(negedge clk);
        check(stat == s0, "R8", "status holds after load", stat, s0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R8 watchdog expired: actual %0h expected %0h", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'd20515));
        build_image(0);
        repeat (2) @(negedge clk);
        // R8: reset state
        check(stat == 8'h10, "R8", "status in reset", stat, 8'h10);
        check(scl && !sda_oe && !reg_we, "R9", "lines in reset", {scl, sda_oe, reg_we}, 4);

        // random images and fixed data corners
        for (int r = 0; r < 5; r++) begin
            build_image(r < 3 ? 0 : r - 2);
            run_load();
            check_full_load(1'b0);
        end

        // R2: bad function indicator
        build_image(0); mem[0] = 8'h5A;
        run_load();
        check(nw == 0, "R2", "writes after bad indicator", nw, 0);
        check(stat == 8'h01, "R2", "status after bad indicator", stat, 8'h01);
        check(nack_ptr == 0, "R2", "NACK word", nack_ptr, 0);
        check_bus_end("R2");

        // R3: bad byte count
        build_image(0); mem[1] = 8'h24;
        run_load();
        check(nw == 0, "R3", "writes after bad count", nw, 0);
        check(stat == 8'h01, "R3", "status after bad count", stat, 8'h01);
        check(nack_ptr == 1, "R3", "NACK word", nack_ptr, 1);
        check_bus_end("R3");

        // R6: wrong end marker
        build_image(0); mem[39] = 8'h7F;
        run_load();
        check_full_load(1'b1);

        // R7: device address not acknowledged
        build_image(0); nack_dev = 1;
        run_load();
        check(nw == 0, "R7", "writes after address NACK", nw, 0);
        check(stat == 8'h01, "R7", "status after address NACK", stat, 8'h01);
        check_bus_end("R7");
        nack_dev = 0;

        // R7: word address not acknowledged
        nack_wa = 1;
        run_load();
        check(nw == 0, "R7", "writes after word address NACK", nw, 0);
        check(stat == 8'h01, "R7", "status after word address NACK", stat, 8'h01);
        check(n_addr == 2, "R7", "address bytes before abort", n_addr, 2);
        check_bus_end("R7");
        nack_wa = 0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule